// File: doc/BRIEF.md
# Bipolar line decoder with three/four-zero substitution removal

This block takes a bipolar line signal presented as two pulse rails (one for positive marks, one for negative marks) together with a per-symbol strobe. It produces a single unipolar serial bit stream. A mode input selects which zero-substitution code is stripped: the three-zero code used on DS3 lines (B3ZS) or the four-zero code used on E3 lines (HDB3). A substitution is recognised by its bipolar violation. The marks that belong to the substitution are turned back into zeros before they leave the block, so the output runs a fixed number of symbols behind the input.

Alongside the data, the block reports line code violations. A violation that fits no legal substitution, or a symbol with both rails active, produces a one-cycle event pulse. These events are counted in a saturating counter that software-side logic can clear. A loss-of-signal flag rises after a programmable run of symbols without any pulse. It drops on the first symbol that carries one.

Top module: `bpd_line_decoder`

## Requirements
- R1: Each symbol strobed by `in_vld` yields one output strobe `vld_o` exactly one clock later. A symbol with only one rail active is a mark and decodes as 1. A symbol with no rail active decodes as 0. While `in_vld` is low, `dat_o`, `lcv_cnt` and `los_o` hold their values.
- R2: With `mode`=0 (B3ZS), `dat_o` carries the symbol received 3 strobes earlier. With `mode`=1 (HDB3), it carries the symbol received 4 strobes earlier. The first 3 or 4 outputs after reset are 0.
- R3: A violation is a single-rail mark with the same polarity as the previous single-rail mark. `pos` means positive. No mark counts as a violation before the first mark after reset. In B3ZS mode, a violation whose preceding symbol was not a mark is a legal substitution: it and the two symbols before it decode as 0.
- R4: In HDB3 mode, a violation whose two preceding symbols were both not marks is a legal substitution: it and the three symbols before it decode as 0.
- R5: A violation that is not a legal substitution for the active mode decodes as 1. It also raises `lcv_o` for one cycle, in the cycle after its strobe.
- R6: A symbol with both rails active raises `lcv_o` and decodes as 0. It does not count as a mark for polarity or for pattern history.
- R7: `lcv_cnt` is 16 bits wide. It increments by one for every `lcv_o` pulse and stays at 0xFFFF once it gets there.
- R8: `lcv_clr` sets `lcv_cnt` to 0. If an event falls in the same cycle as the clear, the count becomes 1.
- R9: `los_o` rises on the strobe that completes `los_lim` consecutive symbols with no rail active, where `los_lim` is at least 1. Any later symbol with a rail active clears it. Cycles without a strobe do not count toward the run.
- R10: While `rst` is high, all outputs are 0, and the polarity and pattern history are forgotten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 = B3ZS decoding, 1 = HDB3 decoding |
| in_vld | input | 1 | Symbol strobe; rails are sampled when high |
| pos | input | 1 | Positive-rail pulse |
| neg | input | 1 | Negative-rail pulse |
| lcv_clr | input | 1 | Clears the violation counter |
| los_lim | input | LOS_W (8) | Zero-run length that raises loss of signal |
| dat_o | output | 1 | Decoded unipolar bit |
| vld_o | output | 1 | Strobe for `dat_o` |
| lcv_o | output | 1 | One-cycle line code violation pulse |
| lcv_cnt | output | CNT_W (16) | Saturating violation count |
| los_o | output | 1 | Loss-of-signal flag |

## Verification
Two functions can act on the counter in the same cycle: a clear request and a new violation event. The bench raises `lcv_clr` in the same cycle it strobes a dual-rail symbol. It then expects the count to read 1, which shows the event was kept rather than lost to the clear. A second clear on its own must then read 0. The same pairing is checked at the top of the range: the counter is driven to 0xFFFE and 0xFFFF, and further events must leave it unchanged.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
  typedef enum logic {
    MODE_B3ZS = 1'b0,
    MODE_HDB3 = 1'b1
  } line_mode_e;

  // longest substitution code handled by the datapath
  localparam int unsigned SUB_MAX = 4;
  localparam int unsigned LEN_W   = $clog2(SUB_MAX + 1);

  function automatic logic [LEN_W-1:0] sub_len(input line_mode_e m);
    return (m == MODE_HDB3) ? LEN_W'(4) : LEN_W'(3);
  endfunction
endpackage

// File: rtl/bpd_sym_class.sv
module bpd_sym_class
  import bpd_pkg::*;
#(
  parameter int unsigned HIST = SUB_MAX
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sym_vld,
  input  logic            pos,
  input  logic            neg,
  input  line_mode_e      mode,
  input  logic [HIST-1:0] mk_hist,   // bit 0 = previous symbol
  output logic            is_mark,
  output logic            any_rail,
  output logic            subst,
  output logic            lcv_evt,
  output logic            dbit
);
  logic last_pos;
  logic have_mark;
  logic single, dual, viol, quiet_pre;

  always_comb begin
    single    = pos ^ neg;
    dual      = pos & neg;
    viol      = single && have_mark && (pos == last_pos);
    // preceding symbols that must be empty for a legal code
    quiet_pre = !mk_hist[0] && ((mode == MODE_B3ZS) || !mk_hist[1]);
    subst     = viol && quiet_pre;
    lcv_evt   = dual || (viol && !quiet_pre);
    dbit      = single && !subst;
    is_mark   = single;
    any_rail  = pos | neg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_pos  <= 1'b0;
      have_mark <= 1'b0;
    end else if (sym_vld && single) begin
      last_pos  <= pos;
      have_mark <= 1'b1;
    end
  end
endmodule

// File: rtl/bpd_delay.sv
module bpd_delay
  import bpd_pkg::*;
#(
  parameter int unsigned DEPTH = SUB_MAX
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift,
  input  logic             din,
  input  logic             mark_in,
  input  logic             subst,
  input  logic [LEN_W-1:0] len,
  output logic [DEPTH-1:0] mk_hist,
  output logic             dout
);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] sr;
  logic [DEPTH-1:0] nxt;
  logic [IW-1:0]    tap;

  assign nxt[0] = din;
  assign tap    = IW'(len - LEN_W'(1));

  for (genvar i = 1; i < DEPTH; i++) begin : g_clr
    // positions that will hold part of the substitution after the shift
    assign nxt[i] = sr[i-1] & ~(subst & (LEN_W'(i) < len));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      mk_hist <= '0;
      dout    <= 1'b0;
    end else if (shift) begin
      sr      <= nxt;
      mk_hist <= {mk_hist[DEPTH-2:0], mark_in};
      dout    <= sr[tap];
    end
  end
endmodule

// File: rtl/bpd_lcv_cnt.sv
module bpd_lcv_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         evt,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= evt ? W'(1) : '0;
    end else if (evt && cnt != TOP) begin
      cnt <= cnt + W'(1);
    end
  end
endmodule

// File: rtl/bpd_los_det.sv
module bpd_los_det #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sym_vld,
  input  logic         active,
  input  logic [W-1:0] lim,
  output logic         los
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] zrun;
  logic [W-1:0] zrun_nx;

  assign zrun_nx = (zrun == TOP) ? zrun : zrun + W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      zrun <= '0;
      los  <= 1'b0;
    end else if (sym_vld) begin
      if (active) begin
        zrun <= '0;
        los  <= 1'b0;
      end else begin
        zrun <= zrun_nx;
        los  <= (zrun_nx >= lim);
      end
    end
  end
endmodule

// File: rtl/bpd_line_decoder.sv
module bpd_line_decoder
  import bpd_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned LOS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode,
  input  logic             in_vld,
  input  logic             pos,
  input  logic             neg,
  input  logic             lcv_clr,
  input  logic [LOS_W-1:0] los_lim,
  output logic             dat_o,
  output logic             vld_o,
  output logic             lcv_o,
  output logic [CNT_W-1:0] lcv_cnt,
  output logic             los_o
);
  line_mode_e        mode_e;
  logic [SUB_MAX-1:0] mk_hist;
  logic              is_mark, any_rail, subst, lcv_evt, dbit;
  logic [LEN_W-1:0]  len;

  assign mode_e = line_mode_e'(mode);
  assign len    = sub_len(mode_e);

  bpd_sym_class #(.HIST(SUB_MAX)) u_cls (
    .clk(clk), .rst(rst), .sym_vld(in_vld), .pos(pos), .neg(neg),
    .mode(mode_e), .mk_hist(mk_hist), .is_mark(is_mark),
    .any_rail(any_rail), .subst(subst), .lcv_evt(lcv_evt), .dbit(dbit)
  );

  bpd_delay #(.DEPTH(SUB_MAX)) u_dly (
    .clk(clk), .rst(rst), .shift(in_vld), .din(dbit), .mark_in(is_mark),
    .subst(subst), .len(len), .mk_hist(mk_hist), .dout(dat_o)
  );

  bpd_lcv_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(lcv_clr), .evt(in_vld && lcv_evt),
    .cnt(lcv_cnt)
  );

  bpd_los_det #(.W(LOS_W)) u_los (
    .clk(clk), .rst(rst), .sym_vld(in_vld), .active(any_rail),
    .lim(los_lim), .los(los_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      lcv_o <= 1'b0;
    end else begin
      vld_o <= in_vld;
      lcv_o <= in_vld && lcv_evt;
    end
  end
endmodule

// File: rtl/bpd_line_decoder_chk.sv
module bpd_line_decoder_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_vld,
  input logic             pos,
  input logic             neg,
  input logic             lcv_clr,
  input logic             dat_o,
  input logic             vld_o,
  input logic             lcv_o,
  input logic [CNT_W-1:0] lcv_cnt,
  input logic             los_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> vld_o);  // R1
  AST_NO_SPURIOUS_STROBE: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !vld_o && !lcv_o);  // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!in_vld && !lcv_clr) |=> $stable(dat_o) && $stable(lcv_cnt) && $stable(los_o));  // R1
  AST_DUAL_RAIL_FLAG: assert property (@(posedge clk) disable iff (rst)
    (in_vld && pos && neg) |=> lcv_o);  // R6
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!lcv_clr && lcv_cnt != TOP) |=> (lcv_cnt == $past(lcv_cnt) + CNT_W'(lcv_o)));  // R7
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
    (!lcv_clr && lcv_cnt == TOP) |=> lcv_cnt == TOP);  // R7
  AST_CLR_RESULT: assert property (@(posedge clk) disable iff (rst)
    lcv_clr |=> lcv_cnt == CNT_W'(lcv_o));  // R8
  AST_LOS_DROP: assert property (@(posedge clk) disable iff (rst)
    (in_vld && (pos || neg)) |=> !los_o);  // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!vld_o && !lcv_o && !los_o && !dat_o && lcv_cnt == '0));  // R10
endmodule

bind bpd_line_decoder bpd_line_decoder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .pos(pos), .neg(neg),
  .lcv_clr(lcv_clr), .dat_o(dat_o), .vld_o(vld_o), .lcv_o(lcv_o),
  .lcv_cnt(lcv_cnt), .los_o(los_o)
);

// File: tb/sim_bpd_line_decoder.sv
`timescale 1ns/1ps
module sim_bpd_line_decoder;
  localparam logic [1:0] Z = 2'd0, P = 2'd1, N = 2'd2, D = 2'd3;

  typedef struct packed {
    logic        mode;
    logic [15:0] syms;   // symbol k in bits [2k+1:2k]
    logic [7:0]  dat;    // expected dat_o after symbol k, bit k
    logic [7:0]  lcv;    // expected lcv_o after symbol k, bit k
  } vec_t;

  // R2 R3 R4 R5 R6 table
  localparam vec_t VECS [0:5] = '{
    '{1'b0, {P,N,P,Z,Z,P,N,P}, 8'h38, 8'h00},  // R3 00V
    '{1'b0, {N,P,N,P,N,Z,N,P}, 8'h88, 8'h00},  // R3 B0V zeroes a mark
    '{1'b0, {Z,N,P,D,Z,N,P,P}, 8'h38, 8'h12},  // R5 R6
    '{1'b1, {N,P,N,P,Z,Z,Z,P}, 8'h10, 8'h00},  // R4 000V
    '{1'b1, {P,N,P,N,Z,Z,N,P}, 8'h10, 8'h00},  // R4 B00V zeroes a mark
    '{1'b1, {N,P,N,P,N,Z,N,P}, 8'hB0, 8'h08}   // R5 illegal in HDB3
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode = 1'b0, in_vld = 1'b0, pos = 1'b0, neg = 1'b0, lcv_clr = 1'b0;
  logic [7:0]  los_lim = 8'd5;
  logic        dat_o, vld_o, lcv_o, los_o;
  logic [15:0] lcv_cnt;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bpd_line_decoder u0 (
    .clk(clk), .rst(rst), .mode(mode), .in_vld(in_vld), .pos(pos), .neg(neg),
    .lcv_clr(lcv_clr), .los_lim(los_lim), .dat_o(dat_o), .vld_o(vld_o),
    .lcv_o(lcv_o), .lcv_cnt(lcv_cnt), .los_o(los_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_vld = 1'b0; pos = 1'b0; neg = 1'b0; lcv_clr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // one strobed symbol, outputs sampled at the following negedge
  task automatic sym(input logic [1:0] c, input logic clr = 1'b0);
    @(negedge clk);
    in_vld = 1'b1; pos = c[0]; neg = c[1]; lcv_clr = clr;
    @(negedge clk);
    in_vld = 1'b0; pos = 1'b0; neg = 1'b0; lcv_clr = 1'b0;
  endtask

  initial begin
    do_reset();
    check("R10 reset dat", dat_o, 0);
    check("R10 reset vld", vld_o, 0);
    check("R10 reset lcv", lcv_o, 0);
    check("R10 reset cnt", lcv_cnt, 0);
    check("R10 reset los", los_o, 0);

    foreach (VECS[v]) begin
      mode = VECS[v].mode;
      do_reset();
      for (int k = 0; k < 8; k++) begin
        sym(VECS[v].syms[2*k +: 2]);
        check("R1 strobe", vld_o, 1);
        check("R2/R3/R4 data", dat_o, VECS[v].dat[k]);
        check("R5/R6 lcv pulse", lcv_o, VECS[v].lcv[k]);
      end
      check("R7 count after vector", lcv_cnt, $countones(VECS[v].lcv));
      repeat (3) @(negedge clk);
      check("R1 idle hold dat", dat_o, VECS[v].dat[7]);
      check("R1 idle no strobe", vld_o, 0);
    end

    // R9 loss of signal
    mode = 1'b0;
    do_reset();
    for (int k = 1; k <= 4; k++) begin
      sym(Z);
      check("R9 los below limit", los_o, 0);
    end
    repeat (4) @(negedge clk);
    check("R9 idle does not count", los_o, 0);
    sym(Z);
    check("R9 los at limit", los_o, 1);
    sym(Z);
    check("R9 los stays", los_o, 1);
    sym(N);
    check("R9 los clears on pulse", los_o, 0);

    // R8 clear coinciding with an event
    do_reset();
    sym(D);
    sym(D);
    check("R7 two events", lcv_cnt, 2);
    sym(D, 1'b1);
    check("R8 clear with event", lcv_cnt, 1);
    @(negedge clk); lcv_clr = 1'b1;
    @(negedge clk); lcv_clr = 1'b0;
    check("R8 clear alone", lcv_cnt, 0);

    // R7 saturation with a streamed dual-rail run
    do_reset();
    @(negedge clk);
    in_vld = 1'b1; pos = 1'b1; neg = 1'b1;
    repeat (65534) @(posedge clk);
    @(negedge clk);
    check("R7 count below top", lcv_cnt, 16'hFFFE);
    repeat (6) @(posedge clk);
    @(negedge clk);
    check("R7 saturated", lcv_cnt, 16'hFFFF);
    in_vld = 1'b0; pos = 1'b0; neg = 1'b0;
    @(negedge clk);
    check("R7 stays saturated", lcv_cnt, 16'hFFFF);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule